// File: doc/BRIEF.md
# Trigger Test Pulse Sequencer

The sequencer watches an incoming trigger line and, while test pulses are enabled, answers each accepted trigger with one test pulse. The pulse starts after a programmable wait measured in slow ticks, each standing for 10 ns. It then stays high for a programmable number of fast ticks, each standing for 4 ns. Both ticks are single-cycle enables in the block's own clock domain. A trigger that arrives while a sequence is running does not restart the sequence. It is counted in a saturating timing-error counter instead.

A small register port holds the configuration and the two bypass flags for the trigger paths, and it reports the error counter and a pulse rate. The rate is the number of pulses started during the last window of a once-per-second enable. Reads are combinational from the address. Writes take effect at the next clock edge.

Top module: `tp_sequencer`

## Requirements
- R1: After reset, pulse_o, busy_o and both bypass outputs are 0, and the registers at addresses 0, 3 and 4 read 0.
- R2: While address 0 bit 0 (enable) is 0, a trigger starts no sequence: busy_o and pulse_o stay 0, and the error counter is unchanged.
- R3: An accepted trigger raises busy_o on the next cycle. After D slow ticks have been counted (D is address 1, bits 11:0), the pulse rises in the cycle after the next fast tick. With D = 0, the pulse rises after the first fast tick.
- R4: The pulse stays high until the L-th fast tick after it starts (L is address 2, bits 11:0), and then it falls together with busy_o. With L = 0, no pulse is produced and busy_o returns to 0.
- R5: Each cycle in which the trigger is high while busy_o is 1 adds one to the error counter (address 3). The running sequence keeps its timing.
- R6: The error counter saturates at its all-ones value and does not wrap.
- R7: Any write to address 3 clears the error counter on the next edge. The clear takes priority over an increment in the same cycle.
- R8: On each cycle of sec_tick_i, address 4 takes the number of pulses started since the previous such cycle, and the window count restarts.
- R9: A write to address 5 sets bypass_main_o from bit 0 and bypass_status_o from bit 1. Both read back at address 5.
- R10: Configuration reads back zero-extended: enable at address 0 bit 0, and the 12-bit values at addresses 1 and 2. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Incoming trigger, sampled each cycle |
| slow_tick_i | input | 1 | 10 ns time-unit enable for the delay |
| fast_tick_i | input | 1 | 4 ns time-unit enable for the pulse length |
| sec_tick_i | input | 1 | One-second window enable for the rate |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| pulse_o | output | 1 | Test pulse |
| busy_o | output | 1 | A sequence is in progress |
| bypass_main_o | output | 1 | Bypass flag for the main trigger path |
| bypass_status_o | output | 1 | Bypass flag for the status trigger path |

## Verification
Register writes become visible one edge after the strobe, and reads are sampled 1 ns after the address is set at a falling edge. The trigger enters the state register at the edge that ends its cycle, so busy_o is checked from the following falling edge onward. Slow ticks fall on every sixth cycle and fast ticks on odd cycles, and triggers are issued only on even cycles. With that pattern, the bench expects exactly D slow ticks while busy_o is high and pulse_o is low. It also expects exactly 2·L cycles of pulse_o, counted at falling edges. Counter and rate values are read only after busy_o has dropped or after the sec_tick_i edge has passed.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_PULSE = 2'd2
  } tp_state_e;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_DELAY  = 1;
  localparam int ADR_LENGTH = 2;
  localparam int ADR_ERRCNT = 3;
  localparam int ADR_RATE   = 4;
  localparam int ADR_BYPASS = 5;

endpackage

// File: rtl/tp_seq_fsm.sv
module tp_seq_fsm
  import tp_pkg::*;
#(
  parameter int CFG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             enable,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic [CFG_W-1:0] delay_cfg,
  input  logic [CFG_W-1:0] len_cfg,
  output logic             pulse,
  output logic             busy,
  output logic             start_ev,
  output logic             retrig_ev
);

  tp_state_e        state_q;
  logic [CFG_W-1:0] remain_q;

  logic accept_ev;
  logic delay_done;
  logic pulse_last;

  function automatic logic [CFG_W-1:0] step_down(input logic [CFG_W-1:0] v);
    return v - CFG_W'(1);
  endfunction

  assign accept_ev  = (state_q == ST_IDLE) && trig && enable;
  assign retrig_ev  = (state_q != ST_IDLE) && trig;
  assign delay_done = (state_q == ST_DELAY) && (remain_q == '0) && fast_tick;
  assign start_ev   = delay_done && (len_cfg != '0);
  assign pulse_last = (state_q == ST_PULSE) && fast_tick && (remain_q == CFG_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept_ev) begin
            state_q  <= ST_DELAY;
            remain_q <= delay_cfg;
          end
        end
        ST_DELAY: begin
          if (remain_q != '0) begin
            if (slow_tick) remain_q <= step_down(remain_q);
          end else if (delay_done) begin
            if (len_cfg != '0) begin
              state_q  <= ST_PULSE;
              remain_q <= len_cfg;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        ST_PULSE: begin
          if (pulse_last)     state_q  <= ST_IDLE;
          else if (fast_tick) remain_q <= step_down(remain_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pulse = (state_q == ST_PULSE);
  assign busy  = (state_q != ST_IDLE);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && trig && !enable) |=> (state_q == ST_IDLE));

  assert_delay_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DELAY && remain_q != '0 && !slow_tick) |=>
      (state_q == ST_DELAY && $stable(remain_q)));

  assert_pulse_on_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(fast_tick));

  assert_pulse_len_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> ($past(len_cfg) != '0));

  assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !fast_tick) |=> pulse);

endmodule

// File: rtl/tp_sat_counter.sv
module tp_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  function automatic logic [W-1:0] sat_next(input logic [W-1:0] cur,
                                            input logic inc_i, input logic clr_i);
    if (clr_i) return '0;
    if (inc_i && cur != TOP) return cur + W'(1);
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= sat_next(count, inc, clr);
  end

  assert_saturate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && inc && !clr) |=> (count == TOP));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count != TOP) |=> (count == $past(count) + W'(1)));

endmodule

// File: rtl/tp_rate_meter.sv
module tp_rate_meter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         event_i,
  input  logic         window_i,
  output logic [W-1:0] rate_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] win_cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt_q <= '0;
      rate_o    <= '0;
    end else if (window_i) begin
      rate_o    <= win_cnt_q;
      win_cnt_q <= event_i ? W'(1) : '0;
    end else if (event_i && win_cnt_q != TOP) begin
      win_cnt_q <= win_cnt_q + W'(1);
    end
  end

  assert_window_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (window_i && !event_i) |=> (win_cnt_q == '0));

  assert_rate_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    window_i |=> (rate_o == $past(win_cnt_q)));

  assert_rate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !window_i |=> $stable(rate_o));

endmodule

// File: rtl/tp_sequencer.sv
module tp_sequencer
  import tp_pkg::*;
#(
  parameter int CFG_W  = 12,
  parameter int ERR_W  = 16,
  parameter int RATE_W = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_i,
  input  logic              slow_tick_i,
  input  logic              fast_tick_i,
  input  logic              sec_tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              pulse_o,
  output logic              busy_o,
  output logic              bypass_main_o,
  output logic              bypass_status_o
);

  logic             en_q;
  logic [CFG_W-1:0] delay_q;
  logic [CFG_W-1:0] len_q;
  logic [1:0]       byp_q;

  logic              start_ev;
  logic              retrig_ev;
  logic              err_clr;
  logic [ERR_W-1:0]  err_cnt;
  logic [RATE_W-1:0] rate_val;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  assign err_clr = reg_we_i && hit(reg_addr_i, ADR_ERRCNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      delay_q <= '0;
      len_q   <= '0;
      byp_q   <= '0;
    end else if (reg_we_i) begin
      if (hit(reg_addr_i, ADR_CTRL))   en_q    <= reg_wdata_i[0];
      if (hit(reg_addr_i, ADR_DELAY))  delay_q <= reg_wdata_i[CFG_W-1:0];
      if (hit(reg_addr_i, ADR_LENGTH)) len_q   <= reg_wdata_i[CFG_W-1:0];
      if (hit(reg_addr_i, ADR_BYPASS)) byp_q   <= reg_wdata_i[1:0];
    end
  end

  tp_seq_fsm #(.CFG_W(CFG_W)) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig_i),
    .enable    (en_q),
    .slow_tick (slow_tick_i),
    .fast_tick (fast_tick_i),
    .delay_cfg (delay_q),
    .len_cfg   (len_q),
    .pulse     (pulse_o),
    .busy      (busy_o),
    .start_ev  (start_ev),
    .retrig_ev (retrig_ev)
  );

  tp_sat_counter #(.W(ERR_W)) err_i (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (retrig_ev),
    .clr   (err_clr),
    .count (err_cnt)
  );

  tp_rate_meter #(.W(RATE_W)) rate_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .event_i  (start_ev),
    .window_i (sec_tick_i),
    .rate_o   (rate_val)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (int'(reg_addr_i))
      ADR_CTRL:   reg_rdata_o = DATA_W'(en_q);
      ADR_DELAY:  reg_rdata_o = DATA_W'(delay_q);
      ADR_LENGTH: reg_rdata_o = DATA_W'(len_q);
      ADR_ERRCNT: reg_rdata_o = DATA_W'(err_cnt);
      ADR_RATE:   reg_rdata_o = DATA_W'(rate_val);
      ADR_BYPASS: reg_rdata_o = DATA_W'(byp_q);
      default:    reg_rdata_o = '0;
    endcase
  end

  assign bypass_main_o   = byp_q[0];
  assign bypass_status_o = byp_q[1];

  assert_bypass_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we_i && hit(reg_addr_i, ADR_BYPASS)) |=>
      ({bypass_status_o, bypass_main_o} == $past(reg_wdata_i[1:0])));

  assert_retrig_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && trig_i && !err_clr && err_cnt == '0) |=> (err_cnt != '0));

  assert_idle_no_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !pulse_o);

endmodule

// File: tb/tp_sequencer_tb.sv
module tp_sequencer_tb_top;

  localparam int ERR_W = 4;
  localparam int ERR_MAX = (1 << ERR_W) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        slow = 1'b0;
  logic        fast = 1'b0;
  logic        sec = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pulse, busy, byp_m, byp_s;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int sc = 0;
  int pc = 0;
  int err_exp = 0;
  int rate_exp = 0;

  always #10 clk = ~clk;

  tp_sequencer #(.ERR_W(ERR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .slow_tick_i(slow),
    .fast_tick_i(fast), .sec_tick_i(sec), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pulse_o(pulse), .busy_o(busy),
    .bypass_main_o(byp_m), .bypass_status_o(byp_s)
  );

  // tick pattern: slow on multiples of 6, fast on odd cycles
  initial begin
    forever begin
      @(posedge clk); #1;
      cyc++;
      slow = (cyc % 6 == 0);
      fast = cyc[0];
    end
  end

  always @(negedge clk) begin
    if (busy && !pulse && slow) sc++;
    if (pulse) pc++;
  end

  task automatic check(input longint act, input longint exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    addr = a[2:0]; wdata = d; we = 1'b1;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    addr = a[2:0];
    #1 d = rdata;
  endtask

  task automatic fire();
    forever begin
      @(posedge clk); #2;
      if (!cyc[0]) break;
    end
    trig = 1'b1;
    @(posedge clk); #2;
    trig = 1'b0;
  endtask

  task automatic run_seq(input int d, input int l, input bit inject);
    int v;
    bit seen;
    seen = 0;
    wr(1, d); wr(2, l);
    sc = 0; pc = 0;
    fire();
    for (int k = 0; k < 2000; k++) begin
      @(negedge clk);
      if (!busy) begin trig = 1'b0; break; end
      trig = inject && ((k == 3) || (pulse && !seen));
      if (inject && trig) err_exp = (err_exp < ERR_MAX) ? err_exp + 1 : ERR_MAX;
      if (pulse) seen = 1;
    end
    if (l != 0) rate_exp++;
    check(sc, d, $sformatf("R3 delay slow ticks d=%0d l=%0d", d, l));
    check(pc, 2 * l, $sformatf("R4 pulse cycles d=%0d l=%0d", d, l));
    rd(3, v);
    check(v, err_exp, "R5 error count after sequence");
  endtask

  task automatic sec_pulse();
    @(posedge clk); #2; sec = 1'b1;
    @(posedge clk); #2; sec = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int v;
    int dl[5] = '{0, 1, 2, 3, 5};
    int ll[5] = '{0, 1, 2, 4, 7};
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(pulse, 0, "R1 pulse after reset");
    check(busy, 0, "R1 busy after reset");
    check({byp_s, byp_m}, 0, "R1 bypass after reset");
    rd(0, v); check(v, 0, "R1 enable after reset");
    rd(3, v); check(v, 0, "R1 error count after reset");
    rd(4, v); check(v, 0, "R1 rate after reset");

    // R2: disabled, trigger ignored
    wr(1, 0); wr(2, 3);
    sc = 0; pc = 0;
    fire();
    repeat (20) begin
      @(negedge clk);
      check(busy, 0, "R2 busy while disabled");
    end
    check(pc, 0, "R2 no pulse while disabled");
    rd(3, v); check(v, 0, "R2 error count unchanged");

    // R10
    wr(0, 32'hFFFF_FFFF); rd(0, v); check(v, 1, "R10 enable readback");
    wr(1, 32'h0000_FABC); rd(1, v); check(v, 32'h0ABC, "R10 delay readback");
    wr(2, 32'h1234_5123); rd(2, v); check(v, 32'h0123, "R10 length readback");
    rd(6, v); check(v, 0, "R10 unmapped address");

    // R3/R4 sweep with window for R8
    sec_pulse();
    rate_exp = 0;
    foreach (dl[i]) foreach (ll[j]) run_seq(dl[i], ll[j], 1'b0);
    sec_pulse();
    rd(4, v); check(v, rate_exp, "R8 rate after sweep");
    rate_exp = 0;
    sec_pulse();
    rd(4, v); check(v, 0, "R8 rate of empty window");

    // R5: retriggers in delay and pulse leave timing intact
    run_seq(3, 4, 1'b1);
    run_seq(2, 2, 1'b1);

    // R6: hold trigger through many delay cycles
    wr(1, 7); wr(2, 1);
    fire();
    @(negedge clk); trig = 1'b1;
    repeat (20) @(negedge clk);
    trig = 1'b0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (!busy) break;
    end
    rd(3, v); check(v, ERR_MAX, "R6 error count saturates");

    // R7: clear
    wr(3, 0);
    rd(3, v); check(v, 0, "R7 error count cleared");
    err_exp = 0;
    run_seq(1, 1, 1'b1);

    // R9
    wr(5, 1); @(negedge clk);
    check({byp_s, byp_m}, 2'b01, "R9 main bypass");
    rd(5, v); check(v, 1, "R9 bypass readback");
    wr(5, 32'hFFFF_FFFE); @(negedge clk);
    check({byp_s, byp_m}, 2'b10, "R9 status bypass");
    rd(5, v); check(v, 2, "R9 bypass readback masked");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule